// File: doc/BRIEF.md
# Sum-of-Products Array with Shared Term Steering

This block is the combinational logic stage of one logic block in a small programmable device. It takes a vector of routed input signals and makes each one available as a true literal and as a complemented literal. A configurable AND plane builds a pool of product terms from those literals. A steering plane then gives each output the OR of any subset of that pool. A single product term may drive several outputs, so logic that several outputs share is built only once.

Configuration is loaded through a row-wide write port before use and does not change while the array evaluates. Rows below the term count hold AND-plane masks. The next rows hold one steering mask per output. Evaluation from the inputs to the sums uses no clock. A flag reports any steering row that selects more terms than one output may take.

Top module: `pterm_alloc_array`

## Requirements
- R1: Reset (active-low `rst_n`) clears every AND-plane and steering row. After reset, `sum_out` is all zeros and `cfg_err` is 0 for any input value.
- R2: Literal column 2i is input i and column 2i+1 is the inverse of input i. A product term is the AND of the literals whose bits are set in its AND-plane row.
- R3: A product term whose AND-plane row has no bits set evaluates to 1.
- R4: A product term that enables both columns of the same input evaluates to 0 for every input value.
- R5: Output o is the OR of the product terms whose bits are set in its steering row. Bit t of that row selects term t.
- R6: An output whose steering row is empty drives 0.
- R7: One product term selected in several steering rows drives all of those outputs at the same time.
- R8: `cfg_err` is 1 exactly when some steering row has more than 16 bits set. A row with exactly 16 bits set does not raise it.
- R9: A write at address a below 86 loads AND-plane row a from `cfg_data[71:0]`. A write at address 86+o, for o from 0 to 15, loads the steering row of output o from `cfg_data[85:0]`. A write at an address of 102 or above changes nothing.
- R10: `sum_out` follows a change on `in_vec` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset that clears the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Row address: AND-plane rows first, then steering rows |
| cfg_data | input | 86 | Row contents to be written |
| in_vec | input | 36 | Routed input signals |
| sum_out | output | 16 | Sum-of-products outputs |
| cfg_err | output | 1 | Set when some output is steered more than 16 terms |

## Verification
The properties assume that configuration changes only through the write strobe on a clock edge and that the reset is held long enough to clear every row. They also assume that inputs need no synchronizing, because the evaluation path holds no state. The stimulus loads each row with a clean write while the clock is low. It changes `in_vec` only between edges. It drives out-of-range addresses and over-full steering rows only in the directed cases meant to exercise them.

// File: rtl/pterm_alloc_array.sv
module pterm_alloc_array #(
  parameter int N_IN      = 36,
  parameter int N_TERM    = 86,
  parameter int N_OUT     = 16,
  parameter int MAX_TERMS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(N_TERM+N_OUT)-1:0] cfg_addr,
  input  logic [((2*N_IN > N_TERM) ? 2*N_IN : N_TERM)-1:0] cfg_data,
  input  logic [N_IN-1:0]              in_vec,
  output logic [N_OUT-1:0]             sum_out,
  output logic                         cfg_err
);

  localparam int LIT    = 2 * N_IN;
  localparam int ROWS   = N_TERM + N_OUT;
  localparam int AW     = $clog2(ROWS);
  localparam int TIDX_W = $clog2(N_TERM);
  localparam int OIDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [AW-1:0] TERM_END = AW'(N_TERM);
  localparam logic [AW-1:0] ROW_END  = AW'(ROWS);

  logic [N_TERM-1:0][LIT-1:0]  plane;
  logic [N_OUT-1:0][N_TERM-1:0] steer;
  logic [LIT-1:0]               lit;
  logic [N_TERM-1:0]            term;
  logic [N_OUT-1:0]             over;

  wire [TIDX_W-1:0] tsel = TIDX_W'(cfg_addr);
  wire [OIDX_W-1:0] osel = OIDX_W'(cfg_addr - TERM_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane <= '0;
      steer <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < TERM_END)
        plane[tsel] <= cfg_data[LIT-1:0];
      else if (cfg_addr < ROW_END)
        steer[osel] <= cfg_data[N_TERM-1:0];
    end
  end

  genvar gi, gt, go;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_lit
      assign lit[2*gi]   = in_vec[gi];
      assign lit[2*gi+1] = ~in_vec[gi];
    end
    for (gt = 0; gt < N_TERM; gt++) begin : g_term
      assign term[gt] = &(~plane[gt] | lit);
    end
    for (go = 0; go < N_OUT; go++) begin : g_out
      assign sum_out[go] = |(steer[go] & term);
      assign over[go]    = ($countones(steer[go]) > MAX_TERMS);

      assert_empty_row_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (steer[go] == '0) |-> !sum_out[go]);
      assert_overfull_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(steer[go]) > MAX_TERMS) |-> cfg_err);
    end
  endgenerate

  assign cfg_err = |over;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sum_out == '0 && !cfg_err));

  assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= ROW_END) |=> ($stable(plane) && $stable(steer)));

  assert_idle_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(plane) && $stable(steer)));

  assert_row_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < TERM_END) |=> (plane[$past(tsel)] == $past(cfg_data[LIT-1:0])));

endmodule

// File: tb/pterm_alloc_array_bench.sv
module pterm_alloc_array_bench;
  localparam int PERIOD = 10;
  localparam int NI = 36, NT = 86, NO = 16;
  localparam int AW = 7, DW = 86;

  logic          clk = 0, rst_n = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] sum_out;
  logic          cfg_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  pterm_alloc_array u_pterm_alloc_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_vec(in_vec), .sum_out(sum_out), .cfg_err(cfg_err));

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed { logic [35:0] iv; logic [15:0] ex; } vec_t;
  localparam vec_t VEC [6] = '{
    '{36'h000000000, 16'h0009},
    '{36'h000000007, 16'h000B},
    '{36'h000000004, 16'h0008},
    '{36'h800000007, 16'h001B},
    '{36'h800000001, 16'h0019},
    '{36'hFFFFFFFFF, 16'h001B}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    in_vec = 36'hFFFFFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(sum_out, 16'h0000, "R1 sums after reset");
    chk({15'd0, cfg_err}, 16'h0000, "R1 flag after reset");

    wr(0, DW'(72'h5));
    wr(1, DW'(72'h20));
    wr(3, DW'(72'h3));
    wr(4, DW'({1'b1, 70'd0}));
    wr(NT+0, DW'(86'h3));
    wr(NT+1, DW'(86'h1));
    wr(NT+2, DW'(86'h8));
    wr(NT+3, DW'(86'h4));
    wr(NT+4, DW'(86'h10));

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_vec = VEC[k].iv;
      #1;
      chk(sum_out, VEC[k].ex, $sformatf("R2 R3 R4 R5 R6 R7 vector %0d", k));
    end

    @(negedge clk);
    in_vec = 36'h000000007;
    #1;
    chk(sum_out, 16'h000B, "R10 before change");
    in_vec = 36'h000000004;
    #1;
    chk(sum_out, 16'h0008, "R10 same phase");

    wr(NT+6, DW'(86'hFFFF)); #1;
    chk({15'd0, cfg_err}, 16'h0000, "R8 exactly sixteen");
    wr(NT+6, DW'(86'h1FFFF)); #1;
    chk({15'd0, cfg_err}, 16'h0001, "R8 seventeen");
    wr(NT+6, DW'(86'h0)); #1;
    chk({15'd0, cfg_err}, 16'h0000, "R8 cleared");

    wr(102, {DW{1'b1}});
    wr(127, {DW{1'b1}});
    @(negedge clk);
    in_vec = 36'h000000007; #1;
    chk(sum_out, 16'h000B, "R9 out of range ignored");
    chk({15'd0, cfg_err}, 16'h0000, "R9 flag unchanged");

    wr(NT+6, DW'(86'h3FFFF));
    @(negedge clk);
    rst_n = 0; #1;
    chk(sum_out, 16'h0000, "R1 reset mid-run sums");
    chk({15'd0, cfg_err}, 16'h0000, "R1 reset mid-run flag");
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule